// File: doc/BRIEF.md
# Interleaved Triangle-Carrier PWM for a Nine-Cell H-Bridge Cluster

This block drives one cluster of series-connected H-bridge cells (nine by default). Every cell owns a triangular carrier built from an up/down counter. All carriers share one period, and each one is shifted from its neighbour by an equal share of that period. The cell's signed modulation index is compared with its carrier to produce the command for each of its two bridge legs. Leg A uses the index as given and leg B uses its negation, so each bridge switches in unipolar fashion. Stacked in series, the cells build a multilevel staircase rather than a single two-level waveform.

Each cell takes its own modulation index, already normalised by the upstream control, so a balancing stage can trim cells one at a time around a common set point. An index is saturated to ±1 and taken in only when that cell's carrier sits at its peak or valley, so a new index cannot add an edge in the middle of a sweep. The two switches of a leg are complementary. Each leg has a short fixed blanking time in which both switches are held off after a change of command. A one-cycle strobe marks the peak of the first cell's carrier, and the upstream control can use it as a sampling instant.

Top module: `shifted_carrier_pwm`

## Requirements
- R1: Every carrier is an integer count that sweeps 0 → CAR_MAX → 0 in steps of one, taking one step per prescaler tick. A tick occurs every TICK_DIV clocks, where TICK_DIV = CLK_HZ / (CARRIER_HZ·2·CAR_MAX) and is at least 1. The first tick comes TICK_DIV clocks after reset is released.
- R2: Cell k runs k·2·CAR_MAX/N_CELLS ticks ahead of cell 0. Cell 0 starts at count 0 and rises. A cell whose offset equals CAR_MAX starts at the peak and falls. A cell whose offset is past CAR_MAX starts falling from 2·CAR_MAX minus its offset.
- R3: The modulation index is a signed MOD_W-bit word in which 2^(MOD_W-2) stands for +1. With latched index m and carrier count c, leg A's command is 1 when m·CAR_MAX > (2c − CAR_MAX)·2^(MOD_W-2). Leg B uses the same test with −m.
- R4: Index words above +2^(MOD_W-2) or below −2^(MOD_W-2) act exactly as +1 or −1.
- R5: A cell takes its index word only on a tick cycle in which its carrier count is 0 or CAR_MAX. Changes at any other time have no effect until the next such cycle.
- R6: Cell k drives gate_o[4k] (leg A upper), gate_o[4k+1] (leg A lower), gate_o[4k+2] (leg B upper) and gate_o[4k+3] (leg B lower). An upper switch follows its leg's command and a lower switch follows its inverse, one clock later.
- R7: A leg's two switches are on only if that leg's command has held for the previous BLANK+1 cycles. After any change both switches stay off for BLANK cycles, and the same holds for the first BLANK+1 cycles after reset.
- R8: While en_i is low, every gate output is 0 from the next cycle on. The carriers keep running.
- R9: While rst_n is low, all gate outputs and peak_o are 0. Every carrier reloads its phase-offset start value.
- R10: peak_o is high for exactly one clock: the first cycle in which cell 0's carrier holds CAR_MAX. It therefore pulses once per carrier period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| en_i | input | 1 | Gate enable; low forces all switches off |
| mod_idx_i | input | N_CELLS·MOD_W | Signed modulation index per cell, cell k in bits [k·MOD_W +: MOD_W] |
| gate_o | output | N_CELLS·4 | Switch commands, four per cell (see R6) |
| peak_o | output | 1 | One-cycle strobe at cell 0 carrier peak |

## Verification
The main comparison runs with indices of zero, half scale of each sign, exactly full scale of each sign, and words beyond full scale. Together these separate a correct threshold from off-by-one compare errors, sign mistakes between legs A and B, and missing saturation. A per-cell ramp of indices shows that each cell uses its own word and its own phase offset rather than a shared one. An index that flips sign every clock exposes any take-over outside the peak and valley cycles. A window with the enable low, a mid-run reset and a peak count over four periods cover the gating, the reload and the strobe.

// File: rtl/psc_pkg.sv
package psc_pkg;

  typedef enum logic {
    CAR_UP   = 1'b0,
    CAR_DOWN = 1'b1
  } car_dir_e;

  // Start count of a carrier that runs 'offset' ticks ahead of phase zero.
  function automatic int preset_count(input int offset, input int car_max);
    if (offset <= car_max) return offset;
    else                   return 2 * car_max - offset;
  endfunction

  // Start direction of that carrier: rising until the peak is reached.
  function automatic car_dir_e preset_dir(input int offset, input int car_max);
    if (offset < car_max) return CAR_UP;
    else                  return CAR_DOWN;
  endfunction

endpackage

// File: rtl/psc_tick.sv
module psc_tick #(
  parameter int DIV = 90
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);

  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [DW-1:0] div_q, div_d;

  assign tick_o = (div_q == LAST);

  always_comb begin
    div_d = div_q + 1'b1;
    if (tick_o) div_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  // R1
  div_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_q <= LAST);

endmodule

// File: rtl/psc_carrier.sv
module psc_carrier
  import psc_pkg::*;
#(
  parameter int CAR_MAX = 4608,
  parameter int OFFSET  = 0,
  parameter int CW      = $clog2(CAR_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  output logic [CW-1:0] cnt_o,
  output logic          extreme_o,
  output logic          pre_peak_o
);

  localparam logic [CW-1:0] CNT_INIT = CW'(preset_count(OFFSET, CAR_MAX));
  localparam car_dir_e      DIR_INIT = preset_dir(OFFSET, CAR_MAX);
  localparam logic [CW-1:0] TOP      = CW'(CAR_MAX);
  localparam logic [CW-1:0] BELOW    = CW'(CAR_MAX - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  car_dir_e      dir_q, dir_d;

  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    if (tick_i) begin
      if (dir_q == CAR_UP) begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == BELOW) dir_d = CAR_DOWN;
      end else begin
        cnt_d = cnt_q - 1'b1;
        if (cnt_q == CW'(1)) dir_d = CAR_UP;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_INIT;
      dir_q <= DIR_INIT;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  assign cnt_o      = cnt_q;
  assign extreme_o  = (cnt_q == '0) || (cnt_q == TOP);
  assign pre_peak_o = (dir_q == CAR_UP) && (cnt_q == BELOW);

  // R1
  carrier_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TOP);

  // R1
  carrier_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(tick_i)) |-> $stable(cnt_q));

  // R1
  carrier_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(tick_i)) |->
      (({1'b0, cnt_q} == {1'b0, $past(cnt_q)} + 1'b1) ||
       ({1'b0, cnt_q} + 1'b1 == {1'b0, $past(cnt_q)})));

endmodule

// File: rtl/psc_modcmp.sv
module psc_modcmp #(
  parameter int MW      = 16,
  parameter int CAR_MAX = 4608,
  parameter int CW      = $clog2(CAR_MAX + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_i,
  input  logic                 extreme_i,
  input  logic [CW-1:0]        cnt_i,
  input  logic signed [MW-1:0] m_i,
  output logic                 cmd_a_o,
  output logic                 cmd_b_o
);

  localparam int ONE = 1 << (MW - 2);
  localparam int PW  = MW + CW + 3;
  localparam logic signed [MW-1:0] POS_ONE = MW'(ONE);
  localparam logic signed [MW-1:0] NEG_ONE = -POS_ONE;
  localparam logic signed [PW-1:0] SCALE   = PW'(CAR_MAX);

  logic signed [MW-1:0] m_sat, m_q, m_d, m_neg;
  logic signed [PW-1:0] lhs_a, lhs_b, car_s, rhs;

  always_comb begin
    if (m_i > POS_ONE)      m_sat = POS_ONE;
    else if (m_i < NEG_ONE) m_sat = NEG_ONE;
    else                    m_sat = m_i;
  end

  always_comb begin
    m_d = m_q;
    if (tick_i && extreme_i) m_d = m_sat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_q <= '0;
    else        m_q <= m_d;
  end

  assign m_neg = -m_q;

  always_comb begin
    lhs_a   = $signed({{(PW-MW){m_q[MW-1]}}, m_q}) * SCALE;
    lhs_b   = $signed({{(PW-MW){m_neg[MW-1]}}, m_neg}) * SCALE;
    car_s   = $signed(PW'({cnt_i, 1'b0})) - SCALE;
    rhs     = car_s <<< (MW - 2);
    cmd_a_o = (lhs_a > rhs);
    cmd_b_o = (lhs_b > rhs);
  end

  // R4
  mlat_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_q <= POS_ONE) && (m_q >= NEG_ONE));

  // R5
  mlat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !($past(tick_i) && $past(extreme_i)) |-> $stable(m_q));

endmodule

// File: rtl/psc_leg.sv
module psc_leg #(
  parameter int BLANK = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic cmd_i,
  output logic hi_o,
  output logic lo_o
);

  localparam int BW = $clog2(BLANK + 2);
  localparam logic [BW-1:0] RELOAD = BW'(BLANK);
  localparam logic [BW-1:0] START  = BW'(BLANK + 1);

  logic          cmd_q, cmd_d;
  logic [BW-1:0] blk_q, blk_d;
  logic          quiet;

  always_comb begin
    cmd_d = cmd_q;
    blk_d = blk_q;
    if (cmd_i != cmd_q) begin
      cmd_d = cmd_i;
      blk_d = RELOAD;
    end else if (blk_q != '0) begin
      blk_d = blk_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= 1'b0;
      blk_q <= START;
    end else begin
      cmd_q <= cmd_d;
      blk_q <= blk_d;
    end
  end

  assign quiet = (blk_q == '0);
  assign hi_o  = en_i & quiet & cmd_q;
  assign lo_o  = en_i & quiet & ~cmd_q;

  // R6
  upper_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_o |-> $past(cmd_i));

  // R6
  lower_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_o |-> !$past(cmd_i));

  // R7
  blank_after_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmd_q) != cmd_q) |-> (!hi_o && !lo_o));

endmodule

// File: rtl/shifted_carrier_pwm.sv
module shifted_carrier_pwm #(
  parameter int N_CELLS    = 9,
  parameter int MOD_W      = 16,
  parameter int CAR_MAX    = 4608,
  parameter int CLK_HZ     = 250_000_000,
  parameter int CARRIER_HZ = 300,
  parameter int BLANK      = 25
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en_i,
  input  logic [N_CELLS*MOD_W-1:0]   mod_idx_i,
  output logic [N_CELLS*4-1:0]       gate_o,
  output logic                       peak_o
);

  localparam int CW       = $clog2(CAR_MAX + 1);
  localparam int SWEEP    = 2 * CAR_MAX;
  localparam int TICK_RAW = CLK_HZ / (CARRIER_HZ * SWEEP);
  localparam int TICK_DIV = (TICK_RAW < 1) ? 1 : TICK_RAW;

  logic              tick;
  logic              en_q, en_d;
  logic              peak_q, peak_d;
  logic [CW-1:0]     car_cnt [N_CELLS];
  logic [N_CELLS-1:0] car_ext;
  logic [N_CELLS-1:0] car_pre;

  psc_tick #(.DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick)
  );

  for (genvar k = 0; k < N_CELLS; k++) begin : g_cell
    logic [1:0] cmd;

    psc_carrier #(
      .CAR_MAX (CAR_MAX),
      .OFFSET  ((k * SWEEP) / N_CELLS),
      .CW      (CW)
    ) u_car (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick),
      .cnt_o      (car_cnt[k]),
      .extreme_o  (car_ext[k]),
      .pre_peak_o (car_pre[k])
    );

    psc_modcmp #(
      .MW      (MOD_W),
      .CAR_MAX (CAR_MAX),
      .CW      (CW)
    ) u_cmp (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick),
      .extreme_i (car_ext[k]),
      .cnt_i     (car_cnt[k]),
      .m_i       ($signed(mod_idx_i[k*MOD_W +: MOD_W])),
      .cmd_a_o   (cmd[0]),
      .cmd_b_o   (cmd[1])
    );

    for (genvar l = 0; l < 2; l++) begin : g_leg
      psc_leg #(.BLANK(BLANK)) u_leg (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (en_q),
        .cmd_i (cmd[l]),
        .hi_o  (gate_o[4*k + 2*l]),
        .lo_o  (gate_o[4*k + 2*l + 1])
      );
    end
  end

  always_comb begin
    en_d   = en_i;
    peak_d = tick & car_pre[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      peak_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      peak_q <= peak_d;
    end
  end

  assign peak_o = peak_q;

  // R10
  peak_at_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    peak_o |-> (car_cnt[0] == CW'(CAR_MAX)));

  // R10
  peak_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    peak_o |=> !peak_o);

  // R8
  idle_gates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en_i) |-> (gate_o == '0));

endmodule

// File: tb/shifted_carrier_pwm_test.sv
module shifted_carrier_pwm_test;

  localparam int N    = 9;
  localparam int MW   = 8;
  localparam int CM   = 18;
  localparam int TD   = 2;
  localparam int BL   = 2;
  localparam int CHZ  = 1000;
  localparam int KHZ  = CHZ * 2 * CM * TD;
  localparam int ONE  = 1 << (MW - 2);
  localparam int PER  = 2 * CM * TD;
  localparam int NV   = 10;

  localparam int V_BASE [NV] = '{0, 32, -32, 64, -64, 100, -128, -40, 20, 7};
  localparam int V_STEP [NV] = '{0, 0, 0, 0, 0, 0, 0, 10, 5, -3};
  localparam int V_EN   [NV] = '{1, 1, 1, 1, 1, 1, 1, 1, 0, 1};

  logic               clk = 1'b0;
  logic               rst_n;
  logic               en;
  logic [N*MW-1:0]    m_in;
  logic [N*4-1:0]     gate;
  logic               peak;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    rst_chk = 1'b0;
  bit    done = 1'b0;
  string tag = "R9";

  int  t;
  bit  en_prev;
  int  exp_m [N];
  int  lc [N][2];
  bit  lv [N][2];

  shifted_carrier_pwm #(
    .N_CELLS    (N),
    .MOD_W      (MW),
    .CAR_MAX    (CM),
    .CLK_HZ     (KHZ),
    .CARRIER_HZ (CHZ),
    .BLANK      (BL)
  ) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (en),
    .mod_idx_i (m_in),
    .gate_o    (gate),
    .peak_o    (peak)
  );

  always #2 clk = ~clk;

  function automatic int sat(input int v);
    if (v > ONE)  return ONE;
    if (v < -ONE) return -ONE;
    return v;
  endfunction

  function automatic int tri_of(input int k, input int cyc);
    int ph;
    ph = ((cyc / TD) + (k * 2 * CM) / N) % (2 * CM);
    return (ph <= CM) ? ph : 2 * CM - ph;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s t=%0d act=%0h exp=%0h", req, what, t, act, exp);
    end
  endtask

  // Reference model, evaluated mid-cycle
  always @(negedge clk) begin
    if (!rst_n) begin
      t = 0;
      en_prev = 1'b0;
      for (int k = 0; k < N; k++) exp_m[k] = 0;
      if (rst_chk) begin
        check(gate == '0, "R9", "gates in reset", longint'(gate), 0);
        check(peak == 1'b0, "R9", "peak in reset", longint'(peak), 0);
      end
    end else if (!done) begin
      logic [N*4-1:0] eg;
      bit ep;
      eg = '0;
      for (int k = 0; k < N; k++) begin
        int tr, lhs, rhs;
        bit c [2];
        tr  = tri_of(k, t);
        rhs = (2 * tr - CM) * ONE;
        lhs = exp_m[k] * CM;
        c[0] = (lhs > rhs);
        c[1] = (-lhs > rhs);
        for (int l = 0; l < 2; l++) begin
          if (t > 0 && en_prev && (t - 1 - BL >= lc[k][l])) begin
            eg[4*k + 2*l]     = lv[k][l];
            eg[4*k + 2*l + 1] = ~lv[k][l];
          end
          if (t == 0 || c[l] != lv[k][l]) begin
            lc[k][l] = t;
            lv[k][l] = c[l];
          end
        end
      end
      ep = (tri_of(0, t) == CM) && ((t % TD) == 0);
      check(gate == eg, tag, "gates", longint'(gate), longint'(eg));
      check(peak == ep, "R10", "peak", longint'(peak), longint'(ep));
      if ((t % TD) == TD - 1) begin
        for (int k = 0; k < N; k++) begin
          int tr;
          tr = tri_of(k, t);
          if (tr == 0 || tr == CM)
            exp_m[k] = sat(int'($signed(m_in[k*MW +: MW])));
        end
      end
      en_prev = en;
      t++;
    end
  end

  task automatic set_all(input int base, input int step);
    for (int k = 0; k < N; k++) m_in[k*MW +: MW] = MW'(base + k * step);
  endtask

  initial begin
    rst_n = 1'b0;
    en    = 1'b0;
    m_in  = '0;
    rst_chk = 1'b1;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    rst_chk = 1'b0;

    // Table walk: R1 R2 R3 R6 R7 on the main compare, R4 on out-of-range words
    for (int v = 0; v < NV; v++) begin
      @(posedge clk);
      #1;
      set_all(V_BASE[v], V_STEP[v]);
      en = V_EN[v][0];
      if (V_EN[v] == 0)                        tag = "R8";
      else if (V_BASE[v] > ONE || V_BASE[v] < -ONE) tag = "R4 R3";
      else                                     tag = "R1 R2 R3 R6 R7";
      repeat (2 * PER) @(posedge clk);
      if (V_EN[v] == 0) begin
        @(negedge clk);
        check(gate == '0, "R8", "gates with enable low", longint'(gate), 0);
      end
    end

    // R5: index flips every clock; only peak/valley samples may count
    tag = "R5";
    for (int i = 0; i < 2 * PER; i++) begin
      @(posedge clk);
      #1 set_all((i % 2 == 1) ? 50 : -50, 0);
    end

    // R10: one strobe per period over four periods
    begin
      int pk;
      pk = 0;
      tag = "R1 R2 R3 R6 R7";
      repeat (4 * PER) begin
        @(negedge clk);
        if (peak) pk++;
      end
      check(pk == 4, "R10", "peak count", pk, 4);
    end

    // R9: mid-run reset, then restart from the phase-offset presets
    @(posedge clk);
    #1 rst_n = 1'b0;
    rst_chk = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    rst_chk = 1'b0;
    tag = "R9 R2";
    set_all(30, -6);
    en = 1'b1;
    repeat (2 * PER) @(posedge clk);

    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule